// File: doc/BRIEF.md
# Interrupt Mask and Status Unit

This block collects single-cycle event pulses from a serial peripheral's datapath into a sticky status register and drives one interrupt request from them. Software decides which events may interrupt by writing ones to a set port or to a clear port. Each of these ports changes only the mask bits that carry a one, and both read back as zero. The mask itself can be read but not written directly.

Status bits stay set until software writes a one to them. A handler can read the status and write the same value back, which acknowledges exactly the events it saw. An event that lands in the same cycle as its own acknowledge is kept, so it is never lost. A second read-only view shows the receive and transmit FIFO level conditions as they are now, whatever the mask holds, so that polling code can use them.

The interrupt output is a registered OR over the status bits whose mask bits are set. It follows the state by one clock.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the mask and status registers are all zero and `irq` is low.
- R2: A write to address 0 sets every mask bit whose write-data bit is 1 and leaves bits written 0 unchanged. The mask reads back at address 2.
- R3: A write to address 1 clears every mask bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R4: Reads of addresses 0 and 1 return zero. Writes to address 2 (mask) and address 4 (level view) change nothing.
- R5: Each event pulse sets its status bit, and the bit holds until it is cleared. The status reads at address 3. The event bit order is: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout.
- R6: A write to address 3 clears the status bits written 1 and leaves bits written 0 unchanged. Writing back a value just read clears exactly those bits.
- R7: If an event pulse arrives in the same cycle as a write-1 clear of that bit, the bit stays set.
- R8: `irq` is high in the cycle after some status bit and its mask bit were both set, and low otherwise.
- R9: Address 4 reads the level inputs regardless of the mask. `lvl_cond[0]` (receive trigger) appears at bit 0, `[1]` (receive empty) at bit 1, `[2]` (transmit empty) at bit 3 and `[3]` (transmit full) at bit 4. All other bits read 0.
- R10: The mask and status are 13 bits wide, and read bits 13 and up are zero. Status bits 9 to 12 have no event source and read zero. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_pulse | input | 9 | One-cycle event pulses in the R5 bit order |
| lvl_cond | input | 4 | Current FIFO level conditions (see R9) |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the in-line properties check the following:
- A set write forces its bits on and a clear write forces its bits off.
- The mask does not move unless one of those two ports is written.
- A status bit is never dropped unless a clear write names it.
- An incoming event always lands.
- `irq` stays low when the mask or the status is empty.
- The level view has nothing outside its four bit positions.

Other behaviour shows only in the bench's scenarios, which compare against a behavioural model every cycle:
- the exact one-cycle latency of `irq`;
- read-back of the value-just-read acknowledge;
- the same-cycle event-versus-clear race;
- the zero readings at the write-only and unused addresses.

// File: rtl/ims_pkg.sv
package ims_pkg;
  localparam int FN_W = 32;

  typedef enum logic [2:0] {
    SEL_ENSET = 3'd0,
    SEL_ENCLR = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_RAW   = 3'd4
  } reg_sel_e;

  localparam int POS_RXTRIG  = 0;
  localparam int POS_RXEMPTY = 1;
  localparam int POS_TXEMPTY = 3;
  localparam int POS_TXFULL  = 4;

  function automatic logic [FN_W-1:0] mask_update(input logic [FN_W-1:0] cur,
                                                  input logic [FN_W-1:0] setv,
                                                  input logic [FN_W-1:0] clrv);
    return (cur | setv) & ~clrv;
  endfunction

  // new events are ORed in after the clear, so an event wins a same-cycle race
  function automatic logic [FN_W-1:0] status_update(input logic [FN_W-1:0] cur,
                                                    input logic [FN_W-1:0] evt,
                                                    input logic [FN_W-1:0] clrv);
    return (cur & ~clrv) | evt;
  endfunction

  function automatic logic [FN_W-1:0] raw_view(input logic [3:0] lvl);
    logic [FN_W-1:0] v;
    v = '0;
    v[POS_RXTRIG]  = lvl[0];
    v[POS_RXEMPTY] = lvl[1];
    v[POS_TXEMPTY] = lvl[2];
    v[POS_TXFULL]  = lvl[3];
    return v;
  endfunction
endpackage

// File: rtl/ims_mask_reg.sv
module ims_mask_reg #(
  parameter int IRQ_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] mask
);
  localparam int FW = ims_pkg::FN_W;

  logic [FW-1:0] set_v, clr_v, nxt;

  assign set_v = set_stb ? FW'(wbits) : '0;
  assign clr_v = clr_stb ? FW'(wbits) : '0;
  assign nxt   = ims_pkg::mask_update(FW'(mask), set_v, clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= nxt[IRQ_W-1:0];
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask & $past(wbits)) == $past(wbits)))
    else $error("mask set write did not take");

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((mask & $past(wbits)) == '0))
    else $error("mask clear write did not take");

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask))
    else $error("mask moved without a set or clear write");
endmodule

// File: rtl/ims_status_reg.sv
module ims_status_reg #(
  parameter int IRQ_W = 13,
  parameter int EVT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic             clr_stb,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] status
);
  localparam int FW = ims_pkg::FN_W;

  logic [IRQ_W-1:0] evt_ext;
  logic [IRQ_W-1:0] clr_bits;
  logic [FW-1:0]    nxt;

  assign evt_ext  = IRQ_W'(evt);
  assign clr_bits = clr_stb ? wbits : '0;
  assign nxt      = ims_pkg::status_update(FW'(status), FW'(evt_ext), FW'(clr_bits));

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (i < EVT_W) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status[i] <= 1'b0;
        else        status[i] <= nxt[i];
      end
    end else begin : g_nosrc
      assign status[i] = 1'b0;
    end
  end

  // R5 R7
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ext != '0) |=> ((status & $past(evt_ext)) == $past(evt_ext)))
    else $error("event pulse was not latched");

  // R6
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_bits) & ~status) == '0))
    else $error("status bit dropped without a clear");
endmodule

// File: rtl/ims_read_mux.sv
module ims_read_mux #(
  parameter int IRQ_W  = 13,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IRQ_W-1:0]  mask,
  input  logic [IRQ_W-1:0]  status,
  input  logic [3:0]        lvl,
  output logic [DATA_W-1:0] rdata
);
  import ims_pkg::*;
  localparam int FW = ims_pkg::FN_W;

  logic [FW-1:0] raw_word;
  assign raw_word = raw_view(lvl);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(SEL_MASK))      rdata = DATA_W'(mask);
    else if (addr == ADDR_W'(SEL_STAT)) rdata = DATA_W'(status);
    else if (addr == ADDR_W'(SEL_RAW))  rdata = DATA_W'(raw_word);
  end

  // R9
  always_comb begin
    if (addr == ADDR_W'(SEL_RAW))
      raw_bits_chk: assert ((rdata & ~DATA_W'(32'h1B)) == '0)
        else $error("level view has bits outside its field");
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 13,
  parameter int EVT_W  = 9,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic [3:0]        lvl_cond,
  output logic              irq
);
  import ims_pkg::*;

  logic             set_stb, clr_stb, ack_stb;
  logic [IRQ_W-1:0] wbits, mask, status, pending;
  logic             wdata_unused;

  assign wbits        = reg_wdata[IRQ_W-1:0];
  assign wdata_unused = ^reg_wdata[DATA_W-1:IRQ_W];
  assign set_stb      = reg_wr && (reg_addr == ADDR_W'(SEL_ENSET));
  assign clr_stb      = reg_wr && (reg_addr == ADDR_W'(SEL_ENCLR));
  assign ack_stb      = reg_wr && (reg_addr == ADDR_W'(SEL_STAT));

  ims_mask_reg #(.IRQ_W(IRQ_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
    .wbits(wbits), .mask(mask));

  ims_status_reg #(.IRQ_W(IRQ_W), .EVT_W(EVT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr_stb(ack_stb),
    .wbits(wbits), .status(status));

  ims_read_mux #(.IRQ_W(IRQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .addr(reg_addr), .mask(mask), .status(status), .lvl(lvl_cond),
    .rdata(reg_rdata));

  assign pending = status & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pending;
  end

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq)
    else $error("irq raised with an empty mask");

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq)
    else $error("irq raised with empty status");
endmodule

// File: tb/tb_irq_mask_unit.sv
`timescale 1ns/1ps
module tb_irq_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  evt_pulse = '0;
  logic [3:0]  lvl_cond = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;

  // behavioural reference state
  int unsigned m_mask = 0, m_stat = 0;
  bit m_irq = 0;

  always #5 clk = ~clk;

  irq_mask_unit dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .lvl_cond(lvl_cond), .irq(irq));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_irq = 0;
    end else begin
      m_irq = ((m_stat & m_mask) != 0);
      if (reg_wr) begin
        if (reg_addr == 0) m_mask = (m_mask | reg_wdata) & 32'h1FFF;
        if (reg_addr == 1) m_mask = m_mask & ~reg_wdata;
        if (reg_addr == 3) m_stat = m_stat & ~reg_wdata;
      end
      m_stat = m_stat | (evt_pulse & 32'h1FF);
    end
  end

  function automatic int unsigned model_read(int a);
    int unsigned v;
    v = 0;
    case (a)
      2: v = m_mask;
      3: v = m_stat;
      4: v = lvl_cond[0] | (lvl_cond[1] << 1) | (lvl_cond[2] << 3) | (lvl_cond[3] << 4);
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    chk("R8 irq", irq, m_irq);
    case (reg_addr)
      0, 1: t = "R4 write-only read";
      2: t = "R2 mask read";
      3: t = "R5 status read";
      4: t = "R9 level view";
      default: t = "R10 unused address";
    endcase
    chk(t, reg_rdata, model_read(reg_addr));
  endtask

  task automatic cyc(input bit wr, input int a, input int unsigned wd,
                     input int unsigned ev, input int unsigned lv);
    reg_wr = wr; reg_addr = a[2:0]; reg_wdata = wd; evt_pulse = ev[8:0]; lvl_cond = lv[3:0];
    @(negedge clk);
    if (cmp_on) compare();
    reg_wr = 0; evt_pulse = '0;
  endtask

  task automatic rd(input int a, input int unsigned exp, input string tag);
    cyc(0, a, 0, 0, lvl_cond);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    rd(2, 0, "R1 mask after reset");
    rd(3, 0, "R1 status after reset");
    // R2 set port
    cyc(1, 0, 32'h0A5, 0, 0);
    rd(2, 32'h0A5, "R2 set bits");
    cyc(1, 0, 32'h100, 0, 0);
    rd(2, 32'h1A5, "R2 zeros keep mask");
    // R4 write-only reads and ignored writes
    rd(0, 0, "R4 set port reads zero");
    rd(1, 0, "R4 clear port reads zero");
    cyc(1, 2, 32'hFFFF, 0, 0);
    cyc(1, 4, 32'hFFFF, 0, 0);
    rd(2, 32'h1A5, "R4 mask unchanged by direct writes");
    // R3 clear port
    cyc(1, 1, 32'h005, 0, 0);
    rd(2, 32'h1A0, "R3 clear bits");
    // R5 event latch, R8 irq latency
    cyc(0, 3, 0, 32'h021, 0);
    chk("R8 irq not yet", irq, 0);
    cyc(0, 3, 0, 0, 0);
    chk("R8 irq one cycle later", irq, 1);
    rd(3, 32'h021, "R5 status holds");
    // R6 write-1 clear
    cyc(1, 3, 32'h001, 0, 0);
    rd(3, 32'h020, "R6 partial clear");
    cyc(1, 3, 32'h020, 0, 0);
    rd(3, 0, "R6 write back read value");
    cyc(0, 3, 0, 0, 0);
    chk("R8 irq drops", irq, 0);
    // R7 race
    cyc(1, 3, 32'h040, 32'h040, 0);
    rd(3, 32'h040, "R7 event beats clear");
    cyc(1, 3, 32'h040, 0, 0);
    // R8 masked event
    cyc(1, 1, 32'h1FFF, 0, 0);
    cyc(0, 3, 0, 32'h1FF, 0);
    repeat (3) cyc(0, 3, 0, 0, 0);
    chk("R8 masked irq low", irq, 0);
    rd(3, 32'h1FF, "R5 all events latched");
    // R9 level view under every input pattern
    for (int p = 0; p < 16; p++) begin
      cyc(0, 4, 0, 0, p);
      chk("R9 level pattern", reg_rdata,
          (p & 1) | (((p >> 1) & 1) << 1) | (((p >> 2) & 1) << 3) | (((p >> 3) & 1) << 4));
    end
    // R10 widths and unused addresses
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0);
    rd(2, 32'h1FFF, "R10 mask width");
    rd(3, 32'h1FF, "R10 status upper bits zero");
    chk("R8 irq with all set", irq, 1);
    rd(5, 0, "R10 address 5");
    rd(6, 0, "R10 address 6");
    rd(7, 0, "R10 address 7");
    cyc(1, 3, 32'hFFFF_FFFF, 0, 0);
    rd(3, 0, "R6 clear all");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule